// File: doc/BRIEF.md
# Conditional Branch and Call Evaluator

This block is the control-flow decision stage of a small 8-bit core. Each cycle it may accept one decoded branch, call or decrement-and-loop operation. From the operation class, a condition selector, the four status flags, register B, the current program counter, the return-to register HL and a displacement, it decides whether control transfers. One clock later it presents the address of the next instruction and the number of core cycles to charge. A taken call also gets a request to push its return address. Stack memory traffic and instruction fetch belong to neighbouring blocks.

All signed displacements are relative to the address of the byte after the instruction. The instruction length is derived from the operation class: 1 byte for the register-indirect jump, 2 for short and loop forms, 3 for word and extended-condition forms. The decrement-and-loop form is the only operation that writes back state. It writes the decremented B and the Zero flag.

Top module: `flow_branch_unit`

## Requirements
- R1: While rst_n is low at a clock edge, and after any cycle in which req_valid was low, res_valid, taken, push_req, b_wr and z_wr are all 0. A request sampled with req_valid high produces its result at the next clock edge with res_valid high.
- R2: For the basic classes (req_kind 0 short jump, 1 word jump, 2 short call, 3 word call) selector 0 takes the branch on Carry set, 1 on Carry clear, 2 on Zero set and 3 on Zero clear. Any other selector value is unconditional.
- R3: For the extended classes (req_kind 4 jump, 5 call) selectors 0..7 mean: less (Overflow differs from Sign), less-or-equal (less, or Zero set), greater (Overflow equals Sign and Zero clear), greater-or-equal (Overflow equals Sign), Overflow set, Overflow clear, Sign clear, Sign set. Selectors 8..15 are never taken.
- R4: A taken relative transfer loads next_pc = cur_pc + length + displacement, modulo 2^16. Lengths are 2 for kinds 0, 2 and 6, and 3 for kinds 1, 3, 4 and 5. Kinds 1 and 3 use all 16 bits of disp. The other kinds use disp[7:0] sign-extended. A not-taken operation gives next_pc = cur_pc + length.
- R5: req_kind 7 is always taken, loads next_pc from reg_hl and costs 8 cycles.
- R6: req_kind 6 sets b_new = reg_b - 1 (modulo 256) with b_wr = 1, and is taken exactly when b_new is non-zero. It writes z_new = 1 when b_new is zero, else 0, with z_wr = 1. It costs 16 cycles.
- R7: Jumps cost a fixed count whether or not taken: 8 for kind 0, 12 for kinds 1 and 4.
- R8: Calls cost 20 taken and 8 not taken for kind 2. They cost 24 taken and 12 not taken for kinds 3 and 5.
- R9: push_req is 1 exactly for a taken call (kinds 2, 3, 5), with push_addr = cur_pc + length. Jumps and not-taken calls never raise it.
- R10: No operation other than kind 6 asserts b_wr or z_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Operation class (encoding in R2-R6) |
| req_sel | input | 4 | Condition selector |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| flag_s | input | 1 | Sign flag |
| reg_b | input | 8 | Current value of register B |
| cur_pc | input | 16 | Address of the first byte of the instruction |
| disp | input | 16 | Displacement; short forms use the low byte |
| reg_hl | input | 16 | Target for the register-indirect jump |
| res_valid | output | 1 | Result present |
| taken | output | 1 | Control transfers |
| next_pc | output | 16 | Address of the next instruction |
| push_req | output | 1 | Push the return address |
| push_addr | output | 16 | Return address to push |
| b_wr | output | 1 | Write b_new into B |
| b_new | output | 8 | Decremented B |
| z_wr | output | 1 | Write z_new into the Zero flag |
| z_new | output | 1 | New Zero flag value |
| cycles | output | 6 | Core cycles charged |

## Verification
The bench targets the signed conditions at their split points. Zero set with Overflow equal to Sign separates less-or-equal from greater, and Sign set with Overflow clear separates less from greater-or-equal. A swapped or inverted term would take the wrong branch there. It checks the loop form at B of 1, which must fall through and set Zero, and at B of 0, which must wrap to 255 and branch. A design that tests B before decrementing fails both. Further vectors give a short displacement whose high byte is garbage, a word displacement that wraps past the top of memory, and a not-taken call. These catch a missing sign extension, a wrong length, or a call that still charges or pushes when its condition fails.

// File: rtl/flow_branch_pkg.sv
// Shared definitions for the branch evaluator: operation classes and
// helpers that depend only on the class.
// Assumes a byte-addressed program space and fixed per-class instruction lengths.
package flow_branch_pkg;

    typedef enum logic [2:0] {
        OP_JMP_SHORT  = 3'd0,
        OP_JMP_WORD   = 3'd1,
        OP_CALL_SHORT = 3'd2,
        OP_CALL_WORD  = 3'd3,
        OP_JMP_EXT    = 3'd4,
        OP_CALL_EXT   = 3'd5,
        OP_LOOP_B     = 3'd6,
        OP_JMP_HL     = 3'd7
    } op_kind_e;

    // True for the classes that save a return address when taken
    function automatic logic kind_is_call(op_kind_e k);
        return (k == OP_CALL_SHORT) || (k == OP_CALL_WORD) || (k == OP_CALL_EXT);
    endfunction

    // Instruction length in bytes
    function automatic logic [1:0] kind_length(op_kind_e k);
        case (k)
            OP_JMP_HL:                                          return 2'd1;
            OP_JMP_SHORT, OP_CALL_SHORT, OP_LOOP_B:             return 2'd2;
            default:                                            return 2'd3;
        endcase
    endfunction

    // True when the class carries a full-width displacement
    function automatic logic kind_wide_disp(op_kind_e k);
        return (k == OP_JMP_WORD) || (k == OP_CALL_WORD);
    endfunction

endpackage

// File: rtl/flow_branch_cond.sv
// Condition decoder: turns a class, a selector, the flags and the
// decremented B into a single take decision. Purely combinational.
// Assumes the caller supplies the already-decremented B for the loop class.
module flow_branch_cond
    import flow_branch_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 4
) (
    input  op_kind_e           kind,
    input  logic [SEL_W-1:0]   sel,
    input  logic               fz,
    input  logic               fc,
    input  logic               fv,
    input  logic               fs,
    input  logic [DATA_W-1:0]  b_dec,
    output logic               take
);

    localparam int BASIC_CODES = 4;
    localparam int EXT_CODES   = 8;

    logic basic_take;
    logic ext_take;
    logic lt;

    // Signed less-than, shared by four extended codes
    assign lt = fv ^ fs;

    // Basic selector decode: carry/zero tests, anything else unconditional
    always_comb begin
        basic_take = 1'b1;
        if (sel < SEL_W'(BASIC_CODES)) begin
            case (sel[1:0])
                2'd0: basic_take = fc;
                2'd1: basic_take = !fc;
                2'd2: basic_take = fz;
                default: basic_take = !fz;
            endcase
        end
    end

    // Extended selector decode: signed and single-flag tests, upper codes never
    always_comb begin
        ext_take = 1'b0;
        if (sel < SEL_W'(EXT_CODES)) begin
            case (sel[2:0])
                3'd0: ext_take = lt;
                3'd1: ext_take = lt || fz;
                3'd2: ext_take = !lt && !fz;
                3'd3: ext_take = !lt;
                3'd4: ext_take = fv;
                3'd5: ext_take = !fv;
                3'd6: ext_take = !fs;
                default: ext_take = fs;
            endcase
        end
    end

    // Pick the decision that belongs to the class
    always_comb begin
        case (kind)
            OP_JMP_EXT, OP_CALL_EXT: take = ext_take;
            OP_LOOP_B:               take = (b_dec != '0);
            OP_JMP_HL:               take = 1'b1;
            default:                 take = basic_take;
        endcase
    end

endmodule

// File: rtl/flow_branch_target.sv
// Address arithmetic: fall-through address and transfer target.
// Assumes displacements are relative to the byte after the instruction
// and that short forms carry a SHORT_W-bit signed field in the low bits.
module flow_branch_target
    import flow_branch_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int SHORT_W = 8
) (
    input  op_kind_e           kind,
    input  logic               take,
    input  logic [ADDR_W-1:0]  pc,
    input  logic [ADDR_W-1:0]  disp,
    input  logic [ADDR_W-1:0]  hl,
    output logic [ADDR_W-1:0]  fall_pc,
    output logic [ADDR_W-1:0]  next_pc
);

    localparam int EXT_BITS = ADDR_W - SHORT_W;

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] rel_pc;

    // Address of the byte following the instruction
    assign fall_pc = pc + ADDR_W'(kind_length(kind));

    // Choose full or sign-extended short displacement
    generate
        if (EXT_BITS > 0) begin : g_sext
            assign disp_ext = kind_wide_disp(kind) ? disp
                            : {{EXT_BITS{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
        end else begin : g_full
            assign disp_ext = disp;
        end
    endgenerate

    assign rel_pc = fall_pc + disp_ext;

    // Final next address: register target, relative target or fall-through
    always_comb begin
        if (kind == OP_JMP_HL)
            next_pc = hl;
        else if (take)
            next_pc = rel_pc;
        else
            next_pc = fall_pc;
    end

endmodule

// File: rtl/flow_branch_cost.sv
// Cycle charge per operation, split by class and outcome.
// Assumes counts fit in CYC_W bits; all counts are parameters.
module flow_branch_cost
    import flow_branch_pkg::*;
#(
    parameter int CYC_W          = 6,
    parameter int C_JMP_SHORT    = 8,
    parameter int C_JMP_WORD     = 12,
    parameter int C_JMP_EXT      = 12,
    parameter int C_JMP_HL       = 8,
    parameter int C_LOOP         = 16,
    parameter int C_CALL_S_TAKE  = 20,
    parameter int C_CALL_S_SKIP  = 8,
    parameter int C_CALL_W_TAKE  = 24,
    parameter int C_CALL_W_SKIP  = 12
) (
    input  op_kind_e           kind,
    input  logic               take,
    output logic [CYC_W-1:0]   cycles
);

    // Lookup of the charge for this class and outcome
    always_comb begin
        case (kind)
            OP_JMP_SHORT:  cycles = CYC_W'(C_JMP_SHORT);
            OP_JMP_WORD:   cycles = CYC_W'(C_JMP_WORD);
            OP_JMP_EXT:    cycles = CYC_W'(C_JMP_EXT);
            OP_JMP_HL:     cycles = CYC_W'(C_JMP_HL);
            OP_LOOP_B:     cycles = CYC_W'(C_LOOP);
            OP_CALL_SHORT: cycles = take ? CYC_W'(C_CALL_S_TAKE) : CYC_W'(C_CALL_S_SKIP);
            default:       cycles = take ? CYC_W'(C_CALL_W_TAKE) : CYC_W'(C_CALL_W_SKIP);
        endcase
    end

endmodule

// File: rtl/flow_branch_unit.sv
// Top of the branch evaluator. Registers one decision per accepted request:
// take, next address, return-address push request, loop-counter write-back
// and cycle charge. Assumes one request per cycle with no back-pressure.
module flow_branch_unit
    import flow_branch_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int SEL_W   = 4,
    parameter int CYC_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [2:0]         req_kind,
    input  logic [SEL_W-1:0]   req_sel,
    input  logic               flag_z,
    input  logic               flag_c,
    input  logic               flag_v,
    input  logic               flag_s,
    input  logic [DATA_W-1:0]  reg_b,
    input  logic [ADDR_W-1:0]  cur_pc,
    input  logic [ADDR_W-1:0]  disp,
    input  logic [ADDR_W-1:0]  reg_hl,
    output logic               res_valid,
    output logic               taken,
    output logic [ADDR_W-1:0]  next_pc,
    output logic               push_req,
    output logic [ADDR_W-1:0]  push_addr,
    output logic               b_wr,
    output logic [DATA_W-1:0]  b_new,
    output logic               z_wr,
    output logic               z_new,
    output logic [CYC_W-1:0]   cycles
);

    op_kind_e           kind;
    logic [DATA_W-1:0]  b_dec;
    logic               take_c;
    logic [ADDR_W-1:0]  fall_c;
    logic [ADDR_W-1:0]  next_c;
    logic [CYC_W-1:0]   cyc_c;
    logic               is_loop;

    assign kind    = op_kind_e'(req_kind);
    assign b_dec   = reg_b - DATA_W'(1);
    assign is_loop = (kind == OP_LOOP_B);

    flow_branch_cond #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_cond (
        .kind  (kind),
        .sel   (req_sel),
        .fz    (flag_z),
        .fc    (flag_c),
        .fv    (flag_v),
        .fs    (flag_s),
        .b_dec (b_dec),
        .take  (take_c)
    );

    flow_branch_target #(.ADDR_W(ADDR_W), .SHORT_W(DATA_W)) u_target (
        .kind    (kind),
        .take    (take_c),
        .pc      (cur_pc),
        .disp    (disp),
        .hl      (reg_hl),
        .fall_pc (fall_c),
        .next_pc (next_c)
    );

    flow_branch_cost #(.CYC_W(CYC_W)) u_cost (
        .kind   (kind),
        .take   (take_c),
        .cycles (cyc_c)
    );

    // Result register: strobes clear when idle, data fields hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            taken     <= 1'b0;
            next_pc   <= '0;
            push_req  <= 1'b0;
            push_addr <= '0;
            b_wr      <= 1'b0;
            b_new     <= '0;
            z_wr      <= 1'b0;
            z_new     <= 1'b0;
            cycles    <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                taken     <= take_c;
                next_pc   <= next_c;
                push_req  <= take_c && kind_is_call(kind);
                push_addr <= fall_c;
                b_wr      <= is_loop;
                b_new     <= b_dec;
                z_wr      <= is_loop;
                z_new     <= (b_dec == '0);
                cycles    <= cyc_c;
            end else begin
                taken    <= 1'b0;
                push_req <= 1'b0;
                b_wr     <= 1'b0;
                z_wr     <= 1'b0;
            end
        end
    end

    // R1: no strobe without a result
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!taken && !push_req && !b_wr && !z_wr));

    // R9: a push request only accompanies a transfer
    p_push_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |-> taken);

    // R10: the flag write only comes with the loop-counter write
    p_flag_loop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        z_wr |-> b_wr);

    // R6: the loop branches exactly when the new Zero is clear
    p_loop_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && b_wr) |-> (taken == !z_new));

    // R7: every charge is one of the legal counts
    p_cost_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (cycles inside {CYC_W'(8), CYC_W'(12), CYC_W'(16), CYC_W'(20), CYC_W'(24)}));

    // R8: a push always charges a taken-call count
    p_call_cost_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push_req |-> (cycles == CYC_W'(20) || cycles == CYC_W'(24)));

endmodule

// File: tb/sim_flow_branch_unit.sv
module sim_flow_branch_unit;

    typedef struct packed {
        logic [2:0]  kind;
        logic [3:0]  sel;
        logic [3:0]  flg;      // {z, c, v, s}
        logic [7:0]  b;
        logic [15:0] pc;
        logic [15:0] dsp;
        logic [15:0] hl;
        logic        e_tk;
        logic [15:0] e_nxt;
        logic        e_psh;
        logic [15:0] e_pa;
        logic [5:0]  e_cyc;
        logic        e_bw;
        logic [7:0]  e_bn;
        logic        e_zn;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VEC [NV] = '{
        // short jump, basic selectors (R2, R4, R7)
        '{3'd0, 4'd0, 4'b0100, 8'h00, 16'h1000, 16'h0010, 16'h0000, 1'b1, 16'h1012, 1'b0, 16'h0000, 6'd8,  1'b0, 8'h00, 1'b0},
        '{3'd0, 4'd0, 4'b0000, 8'h00, 16'h1000, 16'h0010, 16'h0000, 1'b0, 16'h1002, 1'b0, 16'h0000, 6'd8,  1'b0, 8'h00, 1'b0},
        '{3'd0, 4'd1, 4'b0000, 8'h00, 16'h1000, 16'h00F0, 16'h0000, 1'b1, 16'h0FF2, 1'b0, 16'h0000, 6'd8,  1'b0, 8'h00, 1'b0},
        '{3'd0, 4'd2, 4'b1000, 8'h00, 16'h1000, 16'h0005, 16'h0000, 1'b1, 16'h1007, 1'b0, 16'h0000, 6'd8,  1'b0, 8'h00, 1'b0},
        '{3'd0, 4'd3, 4'b1000, 8'h00, 16'h1000, 16'h0005, 16'h0000, 1'b0, 16'h1002, 1'b0, 16'h0000, 6'd8,  1'b0, 8'h00, 1'b0},
        '{3'd0, 4'd4, 4'b0000, 8'h00, 16'h1000, 16'hAB7F, 16'h0000, 1'b1, 16'h1081, 1'b0, 16'h0000, 6'd8,  1'b0, 8'h00, 1'b0},
        // word jump (R2, R4, R7)
        '{3'd1, 4'd4, 4'b0000, 8'h00, 16'h1000, 16'h1234, 16'h0000, 1'b1, 16'h2237, 1'b0, 16'h0000, 6'd12, 1'b0, 8'h00, 1'b0},
        '{3'd1, 4'd3, 4'b0000, 8'h00, 16'h1000, 16'hFFFE, 16'h0000, 1'b1, 16'h1001, 1'b0, 16'h0000, 6'd12, 1'b0, 8'h00, 1'b0},
        '{3'd1, 4'd5, 4'b0000, 8'h00, 16'hFFF0, 16'h0020, 16'h0000, 1'b1, 16'h0013, 1'b0, 16'h0000, 6'd12, 1'b0, 8'h00, 1'b0},
        '{3'd1, 4'd2, 4'b0000, 8'h00, 16'h1000, 16'h1234, 16'h0000, 1'b0, 16'h1003, 1'b0, 16'h0000, 6'd12, 1'b0, 8'h00, 1'b0},
        // short and word calls (R8, R9)
        '{3'd2, 4'd2, 4'b1000, 8'h00, 16'h1000, 16'h0020, 16'h0000, 1'b1, 16'h1022, 1'b1, 16'h1002, 6'd20, 1'b0, 8'h00, 1'b0},
        '{3'd2, 4'd2, 4'b0000, 8'h00, 16'h1000, 16'h0020, 16'h0000, 1'b0, 16'h1002, 1'b0, 16'h0000, 6'd8,  1'b0, 8'h00, 1'b0},
        '{3'd3, 4'd1, 4'b0000, 8'h00, 16'h1000, 16'h0100, 16'h0000, 1'b1, 16'h1103, 1'b1, 16'h1003, 6'd24, 1'b0, 8'h00, 1'b0},
        '{3'd3, 4'd0, 4'b0000, 8'h00, 16'h1000, 16'h0100, 16'h0000, 1'b0, 16'h1003, 1'b0, 16'h0000, 6'd12, 1'b0, 8'h00, 1'b0},
        // extended jumps (R3, R7)
        '{3'd4, 4'd0, 4'b0001, 8'h00, 16'h1000, 16'h0008, 16'h0000, 1'b1, 16'h100B, 1'b0, 16'h0000, 6'd12, 1'b0, 8'h00, 1'b0},
        '{3'd4, 4'd0, 4'b0011, 8'h00, 16'h1000, 16'h0008, 16'h0000, 1'b0, 16'h1003, 1'b0, 16'h0000, 6'd12, 1'b0, 8'h00, 1'b0},
        '{3'd4, 4'd1, 4'b1000, 8'h00, 16'h1000, 16'h0008, 16'h0000, 1'b1, 16'h100B, 1'b0, 16'h0000, 6'd12, 1'b0, 8'h00, 1'b0},
        '{3'd4, 4'd2, 4'b0000, 8'h00, 16'h1000, 16'h0008, 16'h0000, 1'b1, 16'h100B, 1'b0, 16'h0000, 6'd12, 1'b0, 8'h00, 1'b0},
        '{3'd4, 4'd2, 4'b1000, 8'h00, 16'h1000, 16'h0008, 16'h0000, 1'b0, 16'h1003, 1'b0, 16'h0000, 6'd12, 1'b0, 8'h00, 1'b0},
        '{3'd4, 4'd3, 4'b0001, 8'h00, 16'h1000, 16'h0008, 16'h0000, 1'b0, 16'h1003, 1'b0, 16'h0000, 6'd12, 1'b0, 8'h00, 1'b0},
        '{3'd4, 4'd4, 4'b0010, 8'h00, 16'h1000, 16'h0008, 16'h0000, 1'b1, 16'h100B, 1'b0, 16'h0000, 6'd12, 1'b0, 8'h00, 1'b0},
        '{3'd4, 4'd5, 4'b0010, 8'h00, 16'h1000, 16'h0008, 16'h0000, 1'b0, 16'h1003, 1'b0, 16'h0000, 6'd12, 1'b0, 8'h00, 1'b0},
        '{3'd4, 4'd6, 4'b0000, 8'h00, 16'h1000, 16'h0008, 16'h0000, 1'b1, 16'h100B, 1'b0, 16'h0000, 6'd12, 1'b0, 8'h00, 1'b0},
        '{3'd4, 4'd7, 4'b0001, 8'h00, 16'h1000, 16'h0008, 16'h0000, 1'b1, 16'h100B, 1'b0, 16'h0000, 6'd12, 1'b0, 8'h00, 1'b0},
        '{3'd4, 4'd8, 4'b1111, 8'h00, 16'h1000, 16'h0008, 16'h0000, 1'b0, 16'h1003, 1'b0, 16'h0000, 6'd12, 1'b0, 8'h00, 1'b0},
        // extended calls (R3, R8, R9)
        '{3'd5, 4'd3, 4'b0011, 8'h00, 16'h1000, 16'h0008, 16'h0000, 1'b1, 16'h100B, 1'b1, 16'h1003, 6'd24, 1'b0, 8'h00, 1'b0},
        '{3'd5, 4'd11,4'b0000, 8'h00, 16'h1000, 16'h0008, 16'h0000, 1'b0, 16'h1003, 1'b0, 16'h0000, 6'd12, 1'b0, 8'h00, 1'b0},
        // decrement-and-loop (R6)
        '{3'd6, 4'd0, 4'b0000, 8'h05, 16'h1000, 16'h00FE, 16'h0000, 1'b1, 16'h1000, 1'b0, 16'h0000, 6'd16, 1'b1, 8'h04, 1'b0},
        '{3'd6, 4'd0, 4'b0000, 8'h01, 16'h1000, 16'h00FE, 16'h0000, 1'b0, 16'h1002, 1'b0, 16'h0000, 6'd16, 1'b1, 8'h00, 1'b1},
        '{3'd6, 4'd0, 4'b1000, 8'h00, 16'h1000, 16'h0004, 16'h0000, 1'b1, 16'h1006, 1'b0, 16'h0000, 6'd16, 1'b1, 8'hFF, 1'b0},
        // register-indirect jump (R5)
        '{3'd7, 4'd0, 4'b0000, 8'h00, 16'h1000, 16'h0004, 16'hBEEF, 1'b1, 16'hBEEF, 1'b0, 16'h0000, 6'd8,  1'b0, 8'h00, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [3:0]  req_sel = '0;
    logic        flag_z = 1'b0, flag_c = 1'b0, flag_v = 1'b0, flag_s = 1'b0;
    logic [7:0]  reg_b = '0;
    logic [15:0] cur_pc = '0, disp = '0, reg_hl = '0;
    logic        res_valid, taken, push_req, b_wr, z_wr, z_new;
    logic [15:0] next_pc, push_addr;
    logic [7:0]  b_new;
    logic [5:0]  cycles;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    flow_branch_unit u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_sel(req_sel), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
        .flag_s(flag_s), .reg_b(reg_b), .cur_pc(cur_pc), .disp(disp),
        .reg_hl(reg_hl), .res_valid(res_valid), .taken(taken), .next_pc(next_pc),
        .push_req(push_req), .push_addr(push_addr), .b_wr(b_wr), .b_new(b_new),
        .z_wr(z_wr), .z_new(z_new), .cycles(cycles)
    );

    task automatic chk(input string tag, input int idx, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s item %0d: actual %h expected %h", tag, idx, act, exp);
        end
    endtask

    function automatic string cond_tag(input logic [2:0] k);
        case (k)
            3'd0, 3'd1: return "R2 taken";
            3'd2, 3'd3: return "R8 taken";
            3'd4, 3'd5: return "R3 taken";
            3'd6:       return "R6 taken";
            default:    return "R5 taken";
        endcase
    endfunction

    task automatic drive(input vec_t v);
        req_kind = v.kind; req_sel = v.sel;
        {flag_z, flag_c, flag_v, flag_s} = v.flg;
        reg_b = v.b; cur_pc = v.pc; disp = v.dsp; reg_hl = v.hl;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        req_valid = 1'b1;
        drive(VEC[10]);
        repeat (3) @(negedge clk);
        chk("R1 res_valid in reset", 0, 16'(res_valid), 16'h0);
        chk("R1 push_req in reset", 0, 16'(push_req), 16'h0);
        chk("R1 taken in reset", 0, 16'(taken), 16'h0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // table walk
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            chk("R1 res_valid", i, 16'(res_valid), 16'h1);
            chk(cond_tag(VEC[i].kind), i, 16'(taken), 16'(VEC[i].e_tk));
            chk("R4 next_pc", i, next_pc, VEC[i].e_nxt);
            chk("R9 push_req", i, 16'(push_req), 16'(VEC[i].e_psh));
            if (VEC[i].e_psh)
                chk("R9 push_addr", i, push_addr, VEC[i].e_pa);
            chk("R7/R8 cycles", i, 16'(cycles), 16'(VEC[i].e_cyc));
            chk("R10 b_wr", i, 16'(b_wr), 16'(VEC[i].e_bw));
            chk("R10 z_wr", i, 16'(z_wr), 16'(VEC[i].e_bw));
            if (VEC[i].e_bw) begin
                chk("R6 b_new", i, 16'(b_new), 16'(VEC[i].e_bn));
                chk("R6 z_new", i, 16'(z_new), 16'(VEC[i].e_zn));
            end
        end

        // R1: idle cycle after a taken call clears strobes
        drive(VEC[10]);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 push before idle", 100, 16'(push_req), 16'h1);
        @(negedge clk);
        chk("R1 idle res_valid", 100, 16'(res_valid), 16'h0);
        chk("R1 idle push_req", 100, 16'(push_req), 16'h0);
        chk("R1 idle taken", 100, 16'(taken), 16'h0);

        // R1: reset during a loop request drops the write-back
        drive(VEC[27]);
        req_valid = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset drops b_wr", 101, 16'(b_wr), 16'h0);
        chk("R1 reset drops z_wr", 101, 16'(z_wr), 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R6 after reset b_new", 102, 16'(b_new), 16'h04);

        // R2: unconditional short call regardless of flags
        drive(VEC[10]);
        req_sel = 4'd9;
        {flag_z, flag_c, flag_v, flag_s} = 4'b0000;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 sel 9 call taken", 103, 16'(taken), 16'h1);
        chk("R8 sel 9 call cycles", 103, 16'(cycles), 16'd20);

        finish_run();
    end

endmodule